// File: doc/BRIEF.md
# Gradient-Descent Channel Estimate Updater

This block runs one step of an iterative channel-estimate refinement that needs no matrix inversion. Every entry of the estimate matrix is replaced by `A - mu*(A*Rbb - Rbr)`, where `A` is a `ROWS x COLS` matrix of signed 8-bit estimates, `Rbb` is a `COLS x COLS` auto-correlation matrix and `Rbr` is a `ROWS x COLS` cross-correlation matrix. The step size `mu` is `2^-s` and is applied as an arithmetic right shift. The inner product for each entry is built one term per clock through a single shared 8x8 multiplier and one accumulator. The step size therefore costs no multiplier.

The estimate lives in an internal two-bank memory. An iteration reads the old estimate from the active bank and writes each new entry into the other bank. The banks swap only after the last entry has been written, so the host always sees one complete estimate. Between iterations the host loads and reads the active bank through a simple port. Back-to-back `start` pulses chain iterations, so each new iteration works on the previous result. The two correlation matrices sit in external synchronous memories that the block addresses directly.

Top module: `chest_grad_update`

## Requirements
- R1: After reset `busy` and `done` are 0 and bank 0 is the active bank.
- R2: Each new entry at (k,j) equals `A(k,j) - ((S - Rbr(k,j)) >>> s)`, where S is the sum over m of `A(k,m)*Rbb(m,j)`, computed at full width. The shift is arithmetic and rounds toward minus infinity.
- R3: A result above 127 is written as 127, and a result below -128 is written as -128.
- R4: The shift amount `s` is taken from `step_shift` on the accepting edge and is held for the whole iteration. All values 0 to 15 are legal.
- R5: `start`, sampled high while idle, raises `busy` on that edge. `done` is a one-cycle pulse that appears `ROWS*COLS*COLS+3` edges later, on the same edge that `busy` falls.
- R6: A `start` pulse while `busy` is high has no effect on the result or on the timing.
- R7: A host write while `busy` is high is ignored.
- R8: The banks swap on the edge that raises `done`. Host reads then return the new estimate, and the next iteration starts from it.
- R9: `host_rdata` shows the active-bank entry at the `host_raddr` of the previous cycle. Entry (k,j) lives at address `k*COLS+j`.
- R10: The block drives `rbb_addr = m*COLS+j` and `rbr_addr = k*COLS+j`, and expects the data one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one iteration |
| step_shift | input | 4 | Step-size exponent s |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion pulse |
| host_we | input | 1 | Host write enable into the active bank |
| host_addr | input | 4 | Host write address k*COLS+j |
| host_wdata | input | 8 | Host write data (signed) |
| host_raddr | input | 4 | Host read address |
| host_rdata | output | 8 | Host read data, one cycle latency |
| rbb_addr | output | 4 | Auto-correlation memory address |
| rbb_data | input | 8 | Auto-correlation entry (signed) |
| rbr_addr | output | 4 | Cross-correlation memory address |
| rbr_data | input | 16 | Cross-correlation entry (signed) |

## Verification
The bench predicts the timing edge by edge. `busy` is due on the edge that samples `start`, and `done` is due exactly `ROWS*COLS*COLS+3` edges later. A behavioural model compares both on the falling edge of every clock. A host read answers one edge after the address is driven, so the readback task drives the address at a falling edge and compares at the next falling edge. The estimate results are checked only after `done`, against integer arithmetic that the bench evaluates. The iterations cover a plain update, saturation in both directions, the largest shift, and a run that carries a stray `start` and a host write mid-iteration.

// File: rtl/cgu_pkg.sv
package cgu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } cgu_state_e;
endpackage

// File: rtl/cgu_ram.sv
module cgu_ram #(
  parameter int W  = 8,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cgu_seq.sv
module cgu_seq
  import cgu_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int SHW  = 4,
  parameter int AW   = 4,
  parameter int BW   = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [SHW-1:0] step_shift,
  input  logic           fin_valid,
  input  logic           fin_final,
  output logic           busy,
  output logic           done,
  output logic           bank,
  output logic [SHW-1:0] shift_q,
  output logic           iss_valid,
  output logic           iss_first,
  output logic           iss_last,
  output logic           iss_diag,
  output logic           iss_final,
  output logic [AW-1:0]  a_idx,
  output logic [BW-1:0]  rbb_idx,
  output logic [AW-1:0]  out_idx
);
  localparam int KW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;
  localparam logic [KW-1:0] KMAX = KW'(ROWS - 1);
  localparam logic [CW-1:0] CMAX = CW'(COLS - 1);

  cgu_state_e    state;
  logic [KW-1:0] k;
  logic [CW-1:0] j, m;

  always_comb begin
    iss_valid = (state == ST_ISSUE);
    iss_first = (m == '0);
    iss_last  = (m == CMAX);
    iss_diag  = (m == j);
    iss_final = (k == KMAX) && (j == CMAX);
    a_idx     = AW'(int'(k) * COLS + int'(m));
    rbb_idx   = BW'(int'(m) * COLS + int'(j));
    out_idx   = AW'(int'(k) * COLS + int'(j));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      k       <= '0;
      j       <= '0;
      m       <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      bank    <= 1'b0;
      shift_q <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_ISSUE;
            busy    <= 1'b1;
            shift_q <= step_shift;
            k       <= '0;
            j       <= '0;
            m       <= '0;
          end
        end
        ST_ISSUE: begin
          if (m != CMAX) begin
            m <= m + 1'b1;
          end else begin
            m <= '0;
            if (j != CMAX) begin
              j <= j + 1'b1;
            end else begin
              j <= '0;
              if (k != KMAX) k <= k + 1'b1;
              else           state <= ST_DRAIN;
            end
          end
        end
        ST_DRAIN: begin
          if (fin_valid && fin_final) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
            bank  <= ~bank;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: completion is a single-cycle pulse
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5: busy has dropped when done is shown
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R4: the step exponent does not move inside an iteration
  assert_shift_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(shift_q));

  // R8: banks swap only together with the completion pulse
  assert_bank_swap_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(bank) |-> done);

  // R6: terms are issued only inside an accepted iteration
  assert_issue_busy_R6: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> busy);
endmodule

// File: rtl/cgu_mac.sv
module cgu_mac #(
  parameter int EW   = 8,
  parameter int CW   = 8,
  parameter int RW   = 16,
  parameter int AW   = 4,
  parameter int ACCW = 19
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   iss_valid,
  input  logic                   iss_first,
  input  logic                   iss_last,
  input  logic                   iss_diag,
  input  logic                   iss_final,
  input  logic [AW-1:0]          out_idx,
  input  logic signed [EW-1:0]   a_rd,
  input  logic signed [CW-1:0]   rbb_rd,
  input  logic signed [RW-1:0]   rbr_rd,
  output logic                   f_valid,
  output logic                   f_final,
  output logic [AW-1:0]          f_idx,
  output logic signed [ACCW-1:0] acc,
  output logic signed [EW-1:0]   f_aold,
  output logic signed [RW-1:0]   f_rbr
);
  localparam int PW = EW + CW;

  // stage 1: memory data returning
  logic          t1_valid, t1_first, t1_last, t1_diag, t1_final;
  logic [AW-1:0] t1_idx;
  // stage 2: registered product
  logic                 t2_valid, t2_first, t2_last, t2_final;
  logic [AW-1:0]        t2_idx;
  logic signed [PW-1:0] prod;
  logic signed [EW-1:0] aold_q;
  logic signed [RW-1:0] rbr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      t1_valid <= 1'b0;
      t2_valid <= 1'b0;
      f_valid  <= 1'b0;
    end else begin
      t1_valid <= iss_valid;
      t2_valid <= t1_valid;
      f_valid  <= t2_valid && t2_last;
    end
    t1_first <= iss_first;
    t1_last  <= iss_last;
    t1_diag  <= iss_diag;
    t1_final <= iss_final;
    t1_idx   <= out_idx;

    t2_first <= t1_first;
    t2_last  <= t1_last;
    t2_final <= t1_final;
    t2_idx   <= t1_idx;
    prod     <= a_rd * rbb_rd;
    if (t1_valid && t1_diag) aold_q <= a_rd;
    if (t1_valid && t1_last) rbr_q  <= rbr_rd;

    if (t2_valid) acc <= t2_first ? ACCW'(prod) : acc + ACCW'(prod);
    if (t2_valid && t2_last) begin
      f_aold  <= aold_q;
      f_rbr   <= rbr_q;
      f_idx   <= t2_idx;
      f_final <= t2_final;
    end
  end

  // R2: finished entries are spaced by at least one idle cycle
  assert_fin_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    f_valid |=> !f_valid);
endmodule

// File: rtl/cgu_update.sv
module cgu_update #(
  parameter int EW   = 8,
  parameter int RW   = 16,
  parameter int SHW  = 4,
  parameter int ACCW = 19
) (
  input  logic signed [ACCW-1:0] acc,
  input  logic signed [RW-1:0]   rbr,
  input  logic signed [EW-1:0]   aold,
  input  logic [SHW-1:0]         shift,
  output logic signed [EW-1:0]   a_new
);
  localparam int DW = ACCW + 1;
  localparam logic signed [DW:0] MAXV = (DW+1)'(2 ** (EW - 1) - 1);
  localparam logic signed [DW:0] MINV = -(DW+1)'(2 ** (EW - 1));

  logic signed [DW-1:0] diff, shd;
  logic signed [DW:0]   nv;

  always_comb begin
    diff = DW'(acc) - DW'(rbr);
    shd  = diff >>> shift;
    nv   = (DW+1)'(aold) - (DW+1)'(shd);
    if (nv > MAXV)      a_new = EW'(MAXV);
    else if (nv < MINV) a_new = EW'(MINV);
    else                a_new = EW'(nv);
  end
endmodule

// File: rtl/chest_grad_update.sv
module chest_grad_update #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int EW   = 8,
  parameter int CW   = 8,
  parameter int RW   = 16,
  parameter int SHW  = 4,
  parameter int AW   = $clog2(ROWS * COLS),
  parameter int BW   = $clog2(COLS * COLS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [SHW-1:0] step_shift,
  output logic           busy,
  output logic           done,
  input  logic           host_we,
  input  logic [AW-1:0]  host_addr,
  input  logic [EW-1:0]  host_wdata,
  input  logic [AW-1:0]  host_raddr,
  output logic [EW-1:0]  host_rdata,
  output logic [BW-1:0]  rbb_addr,
  input  logic [CW-1:0]  rbb_data,
  output logic [AW-1:0]  rbr_addr,
  input  logic [RW-1:0]  rbr_data
);
  localparam int ACCW = EW + CW + $clog2(COLS) + 1;

  logic           bank, fin_valid, fin_final;
  logic [SHW-1:0] shift_q;
  logic           iss_valid, iss_first, iss_last, iss_diag, iss_final;
  logic [AW-1:0]  a_idx, out_idx, f_idx;
  logic signed [ACCW-1:0] acc;
  logic signed [EW-1:0]   f_aold, a_new;
  logic signed [RW-1:0]   f_rbr;
  logic           ram_we;
  logic [AW:0]    ram_waddr, ram_raddr;
  logic [EW-1:0]  ram_wdata, ram_rdata;

  cgu_seq #(.ROWS(ROWS), .COLS(COLS), .SHW(SHW), .AW(AW), .BW(BW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .step_shift(step_shift),
    .fin_valid(fin_valid), .fin_final(fin_final),
    .busy(busy), .done(done), .bank(bank), .shift_q(shift_q),
    .iss_valid(iss_valid), .iss_first(iss_first), .iss_last(iss_last),
    .iss_diag(iss_diag), .iss_final(iss_final),
    .a_idx(a_idx), .rbb_idx(rbb_addr), .out_idx(out_idx)
  );

  assign rbr_addr = out_idx;

  cgu_mac #(.EW(EW), .CW(CW), .RW(RW), .AW(AW), .ACCW(ACCW)) u_mac (
    .clk(clk), .rst(rst),
    .iss_valid(iss_valid), .iss_first(iss_first), .iss_last(iss_last),
    .iss_diag(iss_diag), .iss_final(iss_final), .out_idx(out_idx),
    .a_rd($signed(ram_rdata)), .rbb_rd($signed(rbb_data)),
    .rbr_rd($signed(rbr_data)),
    .f_valid(fin_valid), .f_final(fin_final), .f_idx(f_idx),
    .acc(acc), .f_aold(f_aold), .f_rbr(f_rbr)
  );

  cgu_update #(.EW(EW), .RW(RW), .SHW(SHW), .ACCW(ACCW)) u_upd (
    .acc(acc), .rbr(f_rbr), .aold(f_aold), .shift(shift_q), .a_new(a_new)
  );

  always_comb begin
    if (fin_valid) begin
      ram_we    = 1'b1;
      ram_waddr = {~bank, f_idx};
      ram_wdata = a_new;
    end else begin
      ram_we    = host_we && !busy;
      ram_waddr = {bank, host_addr};
      ram_wdata = host_wdata;
    end
    ram_raddr = busy ? {bank, a_idx} : {bank, host_raddr};
  end

  cgu_ram #(.W(EW), .AW(AW + 1)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  assign host_rdata = ram_rdata;

  // R7: nothing but the engine writes the memory during an iteration
  assert_host_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !fin_valid) |-> !ram_we);

  // R8: engine writes never target the bank being read
  assert_write_other_bank_R8: assert property (@(posedge clk) disable iff (rst)
    fin_valid |-> (ram_waddr[AW] != ram_raddr[AW]));
endmodule

// File: tb/chest_grad_update_tb.sv
module chest_grad_update_tb;
  localparam int P   = 4;
  localparam int Q   = 4;
  localparam int LAT = P * Q * Q + 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  step_shift = '0;
  logic        busy, done;
  logic        host_we = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [3:0]  host_raddr = '0;
  logic [7:0]  host_rdata;
  logic [3:0]  rbb_addr, rbr_addr;
  logic [7:0]  rbb_data;
  logic [15:0] rbr_data;

  int a_mod [P*Q];
  int rbb_mem [Q*Q];
  int rbr_mem [P*Q];
  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  int m_cnt = 0;
  logic m_busy = 1'b0;
  logic m_done = 1'b0;
  logic mon_on = 1'b0;

  always #4 clk = ~clk;

  chest_grad_update u_dut (
    .clk(clk), .rst(rst), .start(start), .step_shift(step_shift),
    .busy(busy), .done(done),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_raddr(host_raddr), .host_rdata(host_rdata),
    .rbb_addr(rbb_addr), .rbb_data(rbb_data),
    .rbr_addr(rbr_addr), .rbr_data(rbr_data)
  );

  // R10: external correlation memories with one-cycle read latency
  always @(posedge clk) begin
    rbb_data <= 8'(rbb_mem[rbb_addr]);
    rbr_data <= 16'(rbr_mem[rbr_addr]);
  end

  // timing model for busy/done (R5, R6)
  always @(posedge clk) begin
    if (rst) begin
      m_busy = 1'b0; m_done = 1'b0; m_cnt = 0;
    end else if (!m_busy) begin
      m_done = 1'b0;
      if (start) begin m_busy = 1'b1; m_cnt = 0; end
    end else begin
      m_cnt++;
      if (m_cnt == LAT) begin m_busy = 1'b0; m_done = 1'b1; end
      else m_done = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (mon_on) begin
      vectors++;
      if (busy !== m_busy || done !== m_done) begin
        fails++;
        $display("FAIL R5 busy/done act=%b/%b exp=%b/%b", busy, done, m_busy, m_done);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp<=150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  function automatic int sat8(int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  // R2, R3: integer reference of one update step
  task automatic model_step(int s);
    int nxt [P*Q];
    for (int k = 0; k < P; k++)
      for (int j = 0; j < Q; j++) begin
        int sum = 0;
        for (int m = 0; m < Q; m++) sum += a_mod[k*Q+m] * rbb_mem[m*Q+j];
        nxt[k*Q+j] = sat8(a_mod[k*Q+j] - ((sum - rbr_mem[k*Q+j]) >>> s));
      end
    for (int i = 0; i < P*Q; i++) a_mod[i] = nxt[i];
  endtask

  task automatic load_a();
    for (int i = 0; i < P*Q; i++) begin
      @(negedge clk);
      host_we = 1'b1; host_addr = 4'(i); host_wdata = 8'(a_mod[i]);
    end
    @(negedge clk);
    host_we = 1'b0;
  endtask

  // R9: address at one falling edge, data compared at the next
  task automatic readback(string tag);
    for (int i = 0; i < P*Q; i++) begin
      @(negedge clk);
      host_raddr = 4'(i);
      @(negedge clk);
      vectors++;
      if (int'($signed(host_rdata)) != a_mod[i]) begin
        fails++;
        $display("FAIL %s R9 entry %0d act=%0d exp=%0d", tag, i,
                 int'($signed(host_rdata)), a_mod[i]);
      end
    end
  endtask

  task automatic run_iter(int s, bit disturb);
    @(negedge clk);
    start = 1'b1; step_shift = 4'(s);
    @(negedge clk);
    start = 1'b0; step_shift = 4'(15 - s);
    if (disturb) begin
      repeat (3) @(negedge clk);
      start = 1'b1;                       // R6: stray start ignored
      @(negedge clk);
      start = 1'b0;
      host_we = 1'b1; host_addr = 4'd15; host_wdata = 8'd77; // R7
      @(negedge clk);
      host_we = 1'b0;
    end
    for (int w = 0; w < 4 * LAT && !done; w++) @(negedge clk);
    model_step(s);
  endtask

  initial begin
    for (int i = 0; i < P*Q; i++) begin
      a_mod[i]   = (i * 7) % 31 - 15;
      rbr_mem[i] = ((i * 37) % 201 - 100) * 8;
    end
    for (int i = 0; i < Q*Q; i++) rbb_mem[i] = (i * 5) % 17 - 8;

    repeat (3) @(negedge clk);
    vectors++;
    if (busy !== 1'b0 || done !== 1'b0) begin // R1
      fails++;
      $display("FAIL R1 reset busy/done act=%b/%b exp=0/0", busy, done);
    end
    rst = 1'b0;
    mon_on = 1'b1;

    load_a();
    readback("R1 bank0 load");

    run_iter(3, 1'b0);
    readback("R2 R4 shift3");

    for (int i = 0; i < P*Q; i++) rbr_mem[i] = (i % 2 == 0) ? 30000 : -30000;
    run_iter(0, 1'b0);
    readback("R3 R8 saturate");

    for (int i = 0; i < P*Q; i++) rbr_mem[i] = ((i * 53) % 97 - 48) * 64;
    run_iter(15, 1'b0);
    readback("R4 shift15");

    for (int i = 0; i < P*Q; i++) a_mod[i] = 40 - i * 5;
    load_a();
    run_iter(2, 1'b1);
    readback("R6 R7 disturb");

    run_iter(1, 1'b0);
    readback("R8 chained");

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule